// File: doc/BRIEF.md
# Pulse-Count Packet Receiver

This block listens to one serial line that carries packets made only of pulse streams. A stream is a burst of short high pulses. The receiver does not recover a clock: it brings the line into its own clock domain, counts rising edges, and closes a stream once the line has stayed low long enough. The number of pulses in a stream, less one, is the value that the stream carries.

Each packet holds six streams in a fixed order. The first carries a 4-bit combined flag code. The next four carry the four nibbles of the encoded data. The last is a stop stream of exactly two pulses. Once the stop stream closes, the receiver joins the nibbles into two encoded bytes. It uses each byte's 2-bit flag to undo the bit-order reversal and the complement that the sender may have applied, then presents the rebuilt 16-bit word together with a one-cycle valid strobe. A malformed packet produces a one-cycle frame-error strobe in place of the word.

Top module: `pcr_rx`

## Requirements
- R1: The line passes through a two-flop synchronizer. Each rising edge of the synchronized line adds one to the current stream count, however many cycles the pulse stays high.
- R2: A stream closes once the synchronized line has been low for GAP_CYC consecutive cycles (default 3) after at least one edge. A low run of GAP_CYC-1 cycles or fewer between pulses keeps the stream open.
- R3: The first stream of a packet carries the combined flag code, which is its count minus one. Bits [3:2] are the flag of the low encoded byte (DS0) and bits [1:0] are the flag of the high encoded byte (DS1).
- R4: Streams two to five carry nibbles SS0, SS1, SS2 and SS3, each equal to the count minus one. The encoded bytes are DS0 = {SS1, SS0} and DS1 = {SS3, SS2}.
- R5: For each byte, flag bit 0 set means the byte's bit order is reversed (bit i swapped with bit 7-i), and flag bit 1 set means the byte is then complemented. The output word is {decoded DS1, decoded DS0}.
- R6: The sixth stream is the stop stream. When it holds exactly two pulses and no earlier stream was out of range, valid_o is high for exactly one cycle and word_o carries the decoded word and holds it until the next valid packet.
- R7: A stop stream with a count other than two raises frame_err_o for one cycle. valid_o stays low and word_o is left unchanged.
- R8: A flag or nibble stream with more than 16 pulses (value above 15) turns the packet into a frame error when its stop stream closes.
- R9: Synchronous active-high reset clears word_o, valid_o and frame_err_o and restarts stream sequencing at the flag stream, including in the middle of a packet.
- R10: After a frame error, the next packet starts again at the flag stream and decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous serial pulse line |
| word_o | output | 16 | Last correctly decoded word |
| valid_o | output | 1 | One-cycle strobe for a new decoded word |
| frame_err_o | output | 1 | One-cycle strobe for a rejected packet |

## Verification
The decoder is driven with words chosen so that each byte hits one of the four flag cases: no change, reversal only, complement only, and both. Any swap of flag bits, nibble order or byte order therefore gives a visibly wrong word. Wide pulses and in-stream low runs of exactly GAP_CYC-1 cycles separate edge counting from level counting and probe the edge of the gap threshold. Stop streams that are too long or split apart, an over-long nibble stream, and a reset in the middle of a packet each show that a bad frame is rejected, that the held word survives, and that sequencing comes back to the start.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    localparam int NIB_W     = 4;
    localparam int NUM_NIB   = 4;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int FLAG_W    = 2;
    localparam int CF_W      = 4;
    localparam int STOP_CNT  = 2;
    localparam int MAX_VAL   = (1 << NIB_W) - 1;

    typedef enum logic [2:0] {
        ST_FLAG = 3'd0,
        ST_SS0  = 3'd1,
        ST_SS1  = 3'd2,
        ST_SS2  = 3'd3,
        ST_SS3  = 3'd4,
        ST_STOP = 3'd5
    } stream_e;

    typedef struct packed {
        logic [CF_W-1:0]               cf;
        logic [NUM_NIB-1:0][NIB_W-1:0] nib;
    } pkt_fields_t;

    function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    // Undo the sender's encoding: reversal is undone first, then complement.
    function automatic logic [BYTE_W-1:0] undo_byte(input logic [BYTE_W-1:0] b,
                                                    input logic [FLAG_W-1:0] f);
        logic [BYTE_W-1:0] t;
        t = f[0] ? rev_byte(b) : b;
        return f[1] ? ~t : t;
    endfunction

endpackage

// File: rtl/pcr_sync.sv
module pcr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], line_i};
    end

    assign lvl_o  = sh[STAGES-1];
    assign rise_o = sh[STAGES-1] & ~sh[STAGES];

    // R1: an edge is a single-cycle event
    a_r1_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pcr_stream_cnt.sv
module pcr_stream_cnt #(
    parameter int GAP_CYC = 3,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl_i,
    input  logic             rise_i,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int RUN_W = $clog2(GAP_CYC + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [CNT_W-1:0] cnt;
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            run    <= '0;
            done_o <= 1'b0;
            cnt_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (rise_i) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                run <= '0;
            end else if (lvl_i) begin
                run <= '0;
            end else if (cnt != '0 && run == RUN_LAST) begin
                done_o <= 1'b1;
                cnt_o  <= cnt;
                cnt    <= '0;
                run    <= '0;
            end else if (run != RUN_LAST) begin
                run <= run + 1'b1;
            end
        end
    end

    // R2: a closed stream always saw at least one edge
    a_r2_done_nonzero: assert property (@(posedge clk) disable iff (rst)
        done_o |-> cnt_o != '0);
    // R2: two streams cannot close on adjacent cycles
    a_r2_done_spaced: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/pcr_seq.sv
module pcr_seq
    import pcr_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             pkt_stb_o,
    output logic             pkt_ok_o,
    output pkt_fields_t      fields_o
);
    localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(MAX_VAL + 1);
    localparam logic [CNT_W-1:0] CNT_STOP = CNT_W'(STOP_CNT);

    stream_e          idx;
    logic             bad;
    logic [CNT_W-1:0] val;
    logic             over;

    assign val  = cnt_i - 1'b1;
    assign over = cnt_i > CNT_LIM;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= ST_FLAG;
            bad       <= 1'b0;
            pkt_stb_o <= 1'b0;
            pkt_ok_o  <= 1'b0;
            fields_o  <= '0;
        end else begin
            pkt_stb_o <= 1'b0;
            if (done_i) begin
                case (idx)
                    ST_FLAG: fields_o.cf     <= val[CF_W-1:0];
                    ST_SS0:  fields_o.nib[0] <= val[NIB_W-1:0];
                    ST_SS1:  fields_o.nib[1] <= val[NIB_W-1:0];
                    ST_SS2:  fields_o.nib[2] <= val[NIB_W-1:0];
                    ST_SS3:  fields_o.nib[3] <= val[NIB_W-1:0];
                    default: ;
                endcase
                if (idx == ST_STOP) begin
                    pkt_stb_o <= 1'b1;
                    pkt_ok_o  <= !bad && (cnt_i == CNT_STOP);
                    bad       <= 1'b0;
                    idx       <= ST_FLAG;
                end else begin
                    if (over) bad <= 1'b1;
                    idx <= stream_e'(idx + 3'd1);
                end
            end
        end
    end

    // R6: sequencing never leaves the six-stream range
    a_r6_idx_range: assert property (@(posedge clk) disable iff (rst)
        idx <= ST_STOP);
    // R6: a packet result follows a closed stream
    a_r6_stb_after_done: assert property (@(posedge clk) disable iff (rst)
        pkt_stb_o |-> $past(done_i));

endmodule

// File: rtl/pcr_rx.sv
module pcr_rx
    import pcr_pkg::*;
#(
    parameter int GAP_CYC     = 3,
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              frame_err_o
);
    logic             lvl, rise, sdone, pkt_stb, pkt_ok;
    logic [CNT_W-1:0] scnt;
    pkt_fields_t      fields;
    logic [BYTE_W-1:0] ds0, ds1;

    pcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .line_i(line_i), .lvl_o(lvl), .rise_o(rise));

    pcr_stream_cnt #(.GAP_CYC(GAP_CYC), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .lvl_i(lvl), .rise_i(rise),
        .done_o(sdone), .cnt_o(scnt));

    pcr_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .done_i(sdone), .cnt_i(scnt),
        .pkt_stb_o(pkt_stb), .pkt_ok_o(pkt_ok), .fields_o(fields));

    always_comb begin
        ds0 = undo_byte({fields.nib[1], fields.nib[0]}, fields.cf[3:2]);
        ds1 = undo_byte({fields.nib[3], fields.nib[2]}, fields.cf[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o      <= '0;
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            valid_o     <= pkt_stb && pkt_ok;
            frame_err_o <= pkt_stb && !pkt_ok;
            if (pkt_stb && pkt_ok) word_o <= {ds1, ds0};
        end
    end

    // R7: a packet is either accepted or rejected, never both
    a_r7_excl: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && frame_err_o));
    // R7: a rejected packet leaves the held word alone
    a_r7_word_hold: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |-> $stable(word_o));
    // R6: valid is a single-cycle strobe
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

endmodule

// File: tb/tb_pcr_rx.sv
module tb_pcr_rx;
    localparam int GAP   = 3;
    localparam int ALPHA = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_i = 1'b0;
    logic [15:0] word_o;
    logic        valid_o, frame_err_o;

    int errors = 0;
    int checks = 0;
    int vcnt = 0, ecnt = 0, dbl = 0;
    logic prev_v = 1'b0;
    logic [15:0] last_word = '0;

    always #4 clk = ~clk;

    pcr_rx #(.GAP_CYC(GAP)) dut (
        .clk(clk), .rst(rst), .line_i(line_i),
        .word_o(word_o), .valid_o(valid_o), .frame_err_o(frame_err_o));

    always @(negedge clk) begin
        if (rst) begin
            prev_v <= 1'b0;
        end else begin
            if (valid_o) begin
                vcnt++;
                last_word = word_o;
                if (prev_v) dbl++;
            end
            if (frame_err_o) ecnt++;
            prev_v <= valid_o;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        line_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_stream(input int n, input int w, input int lo);
        for (int i = 0; i < n; i++) begin
            line_i = 1'b1;
            repeat (w) @(negedge clk);
            line_i = 1'b0;
            if (i == n - 1) repeat (ALPHA) @(negedge clk);
            else            repeat (lo) @(negedge clk);
        end
    endtask

    task automatic send_pkt(input int c0, input int c1, input int c2, input int c3,
                            input int c4, input int c5, input int w, input int lo);
        send_stream(c0, w, lo);
        send_stream(c1, w, lo);
        send_stream(c2, w, lo);
        send_stream(c3, w, lo);
        send_stream(c4, w, lo);
        send_stream(c5, w, lo);
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [7:0] brev(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7 - i];
        return r;
    endfunction

    // Sender-side encoding: complement when more than half the bits are set,
    // then reverse when that gives a smaller value.
    task automatic enc_byte(input logic [7:0] b, output logic [7:0] e, output logic [1:0] f);
        logic [7:0] t;
        f[1] = ($countones(b) > 4);
        t = f[1] ? ~b : b;
        f[0] = (brev(t) < t);
        e = f[0] ? brev(t) : t;
    endtask

    task automatic send_word(input logic [15:0] wd, input int w, input int lo);
        logic [7:0] e0, e1;
        logic [1:0] f0, f1;
        enc_byte(wd[7:0], e0, f0);
        enc_byte(wd[15:8], e1, f1);
        send_pkt({f0, f1} + 1, e0[3:0] + 1, e0[7:4] + 1, e1[3:0] + 1, e1[7:4] + 1, 2, w, lo);
    endtask

    task automatic expect_ok(input logic [15:0] exp, input int v0, input string tag);
        check(vcnt - v0 == 1, {tag, " valid count"}, vcnt - v0, 1);
        check(last_word == exp, {tag, " word"}, last_word, exp);
    endtask

    task automatic t_reset();
        do_reset();
        check(word_o == 16'h0, "R9 reset word", word_o, 0);
        check(!valid_o && !frame_err_o, "R9 reset strobes", {valid_o, frame_err_o}, 0);
    endtask

    task automatic t_example();
        int v0 = vcnt, e0 = ecnt;
        // cf=14: DS0 flag 3, DS1 flag 2; nibbles 7,0,1,0 (R3 R4 R5 R6)
        send_pkt(15, 8, 1, 2, 1, 2, 1, 1);
        expect_ok(16'hFE1F, v0, "R3 R4 R5 R6 example");
        check(ecnt == e0, "R6 no error", ecnt - e0, 0);
    endtask

    task automatic t_words();
        logic [15:0] ws [6] = '{16'h0000, 16'hFFFF, 16'h0180, 16'hA55A, 16'h1234, 16'h7F3C};
        foreach (ws[k]) begin
            int v0 = vcnt;
            send_word(ws[k], 1, 1);
            expect_ok(ws[k], v0, "R5 flag combos");
        end
    endtask

    task automatic t_wide();
        int v0 = vcnt;
        // R1 wide pulses count once; R2 in-stream lows of GAP-1 keep stream open
        send_word(16'hC3E1, 3, GAP - 1);
        expect_ok(16'hC3E1, v0, "R1 R2 wide pulses");
    endtask

    task automatic t_bad_stop();
        int v0 = vcnt, e0 = ecnt;
        logic [15:0] held = last_word;
        send_pkt(15, 8, 1, 2, 1, 3, 1, 1);
        check(ecnt - e0 == 1, "R7 stop=3 error", ecnt - e0, 1);
        check(vcnt == v0, "R7 no valid", vcnt - v0, 0);
        check(word_o == held, "R7 word held", word_o, held);
        v0 = vcnt;
        send_word(16'h5A0F, 1, 1);
        expect_ok(16'h5A0F, v0, "R10 recover");
    endtask

    task automatic t_overflow();
        int v0 = vcnt, e0 = ecnt;
        send_pkt(1, 17, 1, 1, 1, 2, 1, 1);
        check(ecnt - e0 == 1, "R8 value over 15", ecnt - e0, 1);
        check(vcnt == v0, "R8 no valid", vcnt - v0, 0);
        v0 = vcnt;
        // 16 pulses (value 15) is still legal
        send_pkt(1, 16, 16, 16, 16, 2, 1, 1);
        expect_ok(16'hFFFF, v0, "R8 max value legal");
    endtask

    task automatic t_split();
        int v0 = vcnt, e0 = ecnt;
        send_stream(15, 1, 1);
        send_stream(8, 1, 1);
        send_stream(1, 1, 1);
        send_stream(2, 1, 1);
        send_stream(1, 1, 1);
        // stop pulses separated by GAP lows: splits into 1 + 1 (R2)
        send_stream(1, 1, 1);
        send_stream(1, 1, 1);
        repeat (12) @(negedge clk);
        check(ecnt - e0 == 1, "R2 split stop error", ecnt - e0, 1);
        check(vcnt == v0, "R2 split no valid", vcnt - v0, 0);
        // mid-packet reset then clean packet (R9)
        send_stream(3, 1, 1);
        send_stream(2, 1, 1);
        do_reset();
        check(word_o == 16'h0, "R9 mid reset word", word_o, 0);
        v0 = vcnt;
        send_word(16'h9E27, 1, 1);
        expect_ok(16'h9E27, v0, "R9 after mid reset");
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_words();
        t_wide();
        t_bad_stop();
        t_overflow();
        t_split();
        check(dbl == 0, "R6 single-cycle valid", dbl, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule